// File: doc/BRIEF.md
# Suspend Wake Source Gate

This block decides which remote wakeup events are allowed to wake a suspended USB device function. Software selects one of three suspend levels through a small level register. While the suspend input is high, the block opens only the wake sources that the current level permits and latches each accepted event into a sticky status vector. The status vector holds its bits until software clears them with a write-one-to-clear.

A remote wakeup request is raised whenever the function is suspended and any status bit is set. The block also drives a ladder of clock-stop enables, one per clock domain. A deeper level stops a superset of the domains that a shallower level stops.

Eight general-purpose wake pins arrive asynchronously. Each pin passes through a two-stage synchronizer and a rising-edge detector, and each pin has its own enable. Frame detection, resume signalling on the bus and power switching all live outside this block.

Top module: `susp_wake_gate`

## Requirements
- R1: The level register resets to 2. A write takes effect on the next cycle and reads back on `level_o`. Writing the code 3 stores 2.
- R2: At level 0 the wake sources are GPIO, the frame-match pulse and the magic-packet pulse. A link-change pulse at level 0 is ignored.
- R3: At level 1 the wake sources are GPIO and the link-change pulse. Frame-match and magic-packet pulses at level 1 are ignored.
- R4: At level 2 only GPIO rising edges wake the function. All three network pulses are ignored.
- R5: A GPIO wake counts only on a rising edge of a pin whose enable bit is 1. The status bit sets on the third rising clock edge after the pin rises, because the pin passes two synchronizer flops and an edge flop. A pin whose enable is 0 sets nothing.
- R6: Events that arrive while `suspend_i` is low are ignored and set no status bit.
- R7: The status layout is bits [7:0] for the GPIO pins, bit 8 for frame match, bit 9 for magic packet and bit 10 for link change. Bits are sticky and clear only when `clr_we_i` is high with a 1 in that bit of `clr_data_i`. A new event in the same cycle as its clear leaves the bit set.
- R8: `wake_req_o` is high exactly when `suspend_i` is high and at least one status bit is set.
- R9: The `clk_stop_o` bits are [0] MAC domain, [1] other internal modules, [2] frame-match logic and [3] link monitor. While suspended, level 0 gives 4'b0011, level 1 gives 4'b0111 and level 2 gives 4'b1111. All bits are 0 whenever `suspend_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lvl_we_i | input | 1 | Level register write strobe |
| lvl_wdata_i | input | 2 | Level to write |
| level_o | output | 2 | Current suspend level |
| suspend_i | input | 1 | Function is suspended |
| gpio_i | input | 8 | Asynchronous wake pins |
| gpio_wake_en_i | input | 8 | Per-pin wake enable |
| wol_match_i | input | 1 | Wake frame matched, one-cycle pulse |
| magic_pkt_i | input | 1 | Magic packet seen, one-cycle pulse |
| link_chg_i | input | 1 | Link status changed, one-cycle pulse |
| clr_we_i | input | 1 | Status clear strobe |
| clr_data_i | input | 11 | Write-one-to-clear mask |
| status_o | output | 11 | Sticky wake source status |
| wake_req_o | output | 1 | Remote wakeup request |
| clk_stop_o | output | 4 | Clock-stop enables per domain |

## Verification
The assertions watch several rules on every cycle. A network status bit may rise only when the level permitted it and its pulse was present. No bit may rise while the function is awake. Bits fall only under a clear. The wake request follows suspend and status, and the clock-stop ladder stays nested and drops to zero out of suspend. Other behaviour shows only in the bench scenarios: the exact three-edge GPIO latency, disabled pins being ignored, the reset level, the 3-to-2 mapping, and the same-cycle set-over-clear rule.

// File: rtl/susp_wake_gate.sv
module susp_wake_gate #(
  parameter int GPIO_N      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int STAT_W     = GPIO_N + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lvl_we_i,
  input  logic [1:0]        lvl_wdata_i,
  output logic [1:0]        level_o,
  input  logic              suspend_i,
  input  logic [GPIO_N-1:0] gpio_i,
  input  logic [GPIO_N-1:0] gpio_wake_en_i,
  input  logic              wol_match_i,
  input  logic              magic_pkt_i,
  input  logic              link_chg_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_data_i,
  output logic [STAT_W-1:0] status_o,
  output logic              wake_req_o,
  output logic [3:0]        clk_stop_o
);

  logic [1:0]        lvl_q;
  logic [GPIO_N-1:0] sync_q [SYNC_STAGES];
  logic [GPIO_N-1:0] gpio_prev_q;
  logic [GPIO_N-1:0] gpio_rise;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] hit;
  logic [STAT_W-1:0] clr_mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        lvl_q <= 2'd2;
    else if (lvl_we_i) lvl_q <= (lvl_wdata_i == 2'd3) ? 2'd2 : lvl_wdata_i;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= (s == 0) ? gpio_i : sync_q[(s == 0) ? 0 : s-1];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) gpio_prev_q <= '0;
    else        gpio_prev_q <= sync_q[SYNC_STAGES-1];

  assign gpio_rise = sync_q[SYNC_STAGES-1] & ~gpio_prev_q & gpio_wake_en_i;

  assign hit = {link_chg_i  & suspend_i & (lvl_q == 2'd1),
                magic_pkt_i & suspend_i & (lvl_q == 2'd0),
                wol_match_i & suspend_i & (lvl_q == 2'd0),
                gpio_rise   & {GPIO_N{suspend_i}}};

  assign clr_mask = clr_we_i ? clr_data_i : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | hit;

  assign level_o    = lvl_q;
  assign status_o   = stat_q;
  assign wake_req_o = suspend_i & (|stat_q);
  assign clk_stop_o = !suspend_i      ? 4'b0000 :
                      (lvl_q == 2'd0) ? 4'b0011 :
                      (lvl_q == 2'd1) ? 4'b0111 : 4'b1111;

endmodule

// File: rtl/susp_wake_gate_chk.sv
module susp_wake_gate_chk #(
  parameter int GPIO_N = 8,
  localparam int STAT_W = GPIO_N + 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        level_o,
  input logic              suspend_i,
  input logic              wol_match_i,
  input logic              magic_pkt_i,
  input logic              link_chg_i,
  input logic              clr_we_i,
  input logic [STAT_W-1:0] clr_data_i,
  input logic [STAT_W-1:0] status_o,
  input logic              wake_req_o,
  input logic [3:0]        clk_stop_o
);

  assert_level_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    level_o != 2'd3);

  assert_wol_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[GPIO_N]) |-> $past(suspend_i && level_o == 2'd0 && wol_match_i));

  assert_magic_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[GPIO_N+1]) |-> $past(suspend_i && level_o == 2'd0 && magic_pkt_i));

  assert_link_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[GPIO_N+2]) |-> $past(suspend_i && level_o == 2'd1 && link_chg_i));

  assert_awake_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(suspend_i) |-> ((status_o & ~$past(status_o)) == '0));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status_o) & ~status_o & ~($past(clr_we_i) ? $past(clr_data_i) : '0)) == '0));

  assert_req_needs_susp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> (suspend_i && status_o != '0));

  assert_req_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_i && status_o != '0) |-> wake_req_o);

  assert_clk_awake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !suspend_i |-> (clk_stop_o == 4'b0000));

  assert_clk_nested_R9: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_i |-> (clk_stop_o[0] && clk_stop_o[1] &&
                   (clk_stop_o[3] -> clk_stop_o[2]) && (clk_stop_o[3] == (level_o == 2'd2))));

endmodule

bind susp_wake_gate susp_wake_gate_chk #(.GPIO_N(GPIO_N)) chk_i (
  .clk(clk), .rst_n(rst_n), .level_o(level_o), .suspend_i(suspend_i),
  .wol_match_i(wol_match_i), .magic_pkt_i(magic_pkt_i), .link_chg_i(link_chg_i),
  .clr_we_i(clr_we_i), .clr_data_i(clr_data_i), .status_o(status_o),
  .wake_req_o(wake_req_o), .clk_stop_o(clk_stop_o));

// File: tb/susp_wake_gate_tb_top.sv
module susp_wake_gate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        lvl_we_i = 0;
  logic [1:0]  lvl_wdata_i = 0;
  logic [1:0]  level_o;
  logic        suspend_i = 0;
  logic [7:0]  gpio_i = 0, gpio_wake_en_i = 0;
  logic        wol_match_i = 0, magic_pkt_i = 0, link_chg_i = 0;
  logic        clr_we_i = 0;
  logic [10:0] clr_data_i = 0;
  logic [10:0] status_o;
  logic        wake_req_o;
  logic [3:0]  clk_stop_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  susp_wake_gate dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_stop(int lvl, bit susp);
    if (!susp) return 4'b0000;
    return (lvl == 0) ? 4'b0011 : (lvl == 1) ? 4'b0111 : 4'b1111;
  endfunction

  // src: 0 gpio, 1 frame match, 2 magic, 3 link
  function automatic logic [10:0] exp_stat(int lvl, bit susp, int src, int gi, logic [7:0] en);
    logic [10:0] r = '0;
    if (!susp) return r;
    case (src)
      0: r[gi] = en[gi];
      1: r[8]  = (lvl == 0);
      2: r[9]  = (lvl == 0);
      default: r[10] = (lvl == 1);
    endcase
    return r;
  endfunction

  task automatic set_level(int w);
    @(negedge clk); lvl_we_i = 1; lvl_wdata_i = w[1:0];
    @(negedge clk); lvl_we_i = 0;
  endtask

  task automatic clear_all;
    @(negedge clk); clr_we_i = 1; clr_data_i = '1;
    @(negedge clk); clr_we_i = 0; clr_data_i = '0;
  endtask

  task automatic fire(int src, int gi);
    @(negedge clk);
    case (src)
      0: begin
        gpio_i[gi] = 1;
        repeat (3) @(negedge clk);
      end
      1: begin wol_match_i = 1; @(negedge clk); wol_match_i = 0; end
      2: begin magic_pkt_i = 1; @(negedge clk); magic_pkt_i = 0; end
      default: begin link_chg_i = 1; @(negedge clk); link_chg_i = 0; end
    endcase
  endtask

  task automatic gpio_release;
    gpio_i = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 reset level", level_o, 2);
    check("R7 reset status", status_o, 0);
    check("R8 reset req", wake_req_o, 0);
    check("R9 reset clk stop", clk_stop_o, 0);
    rst_n = 1;
    @(negedge clk);

    set_level(3);
    check("R1 write 3 stores 2", level_o, 2);
    set_level(1);
    check("R1 write 1", level_o, 1);

    // R5 exact latency: bit not yet set after two edges, set after three
    set_level(2); suspend_i = 1; gpio_wake_en_i = 8'h01;
    @(negedge clk); gpio_i[0] = 1;
    repeat (2) @(negedge clk);
    check("R5 gpio not yet latched", status_o, 0);
    @(negedge clk);
    check("R5 gpio latched third edge", status_o, 11'h001);
    gpio_release();
    clear_all();

    // R7 set wins over clear, partial clear
    set_level(0);
    @(negedge clk); wol_match_i = 1;
    @(negedge clk); wol_match_i = 0;
    magic_pkt_i = 1; clr_we_i = 1; clr_data_i = 11'h300;
    @(negedge clk); magic_pkt_i = 0; clr_we_i = 0; clr_data_i = 0;
    check("R7 set over clear", status_o, 11'h200);
    @(negedge clk); clr_we_i = 1; clr_data_i = 11'h100;
    @(negedge clk); clr_we_i = 0; clr_data_i = 0;
    check("R7 clear of unset bit keeps others", status_o, 11'h200);
    suspend_i = 0;
    @(negedge clk);
    check("R8 req drops out of suspend", wake_req_o, 0);
    check("R9 clk stop zero awake", clk_stop_o, 0);
    suspend_i = 1;
    clear_all();

    // Constrained random scenarios
    for (int it = 0; it < 300; it++) begin
      int w   = $urandom_range(0, 3);
      int lvl = (w == 3) ? 2 : w;
      bit sus = ($urandom_range(0, 3) != 0);
      int src = $urandom_range(0, 3);
      int gi  = $urandom_range(0, 7);
      logic [7:0] en = 8'($urandom);
      logic [10:0] e;
      suspend_i = 0;
      set_level(w);
      clear_all();
      gpio_wake_en_i = en;
      suspend_i = sus;
      @(negedge clk);
      check("R1 level", level_o, lvl);
      check("R9 clk stop", clk_stop_o, exp_stop(lvl, sus));
      fire(src, gi);
      e = exp_stat(lvl, sus, src, gi, en);
      case (src)
        0:       check(sus ? "R5 gpio wake" : "R6 gpio awake", status_o, e);
        1, 2:    check(!sus ? "R6 pkt awake" : lvl == 0 ? "R2 pkt level0" : lvl == 1 ? "R3 pkt level1" : "R4 pkt level2", status_o, e);
        default: check(!sus ? "R6 link awake" : lvl == 0 ? "R2 link level0" : lvl == 1 ? "R3 link level1" : "R4 link level2", status_o, e);
      endcase
      check("R8 wake req", wake_req_o, sus && (e != 0));
      if (src == 0) gpio_release();
      check("R7 sticky", status_o, e);
    end

    suspend_i = 0;
    clear_all();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule